// File: doc/BRIEF.md
# Change-of-state digital input controller

This block samples a bank of 48 digital input lines and tells the host when any of them changes level. The lines are handled as six groups of eight. Each group owns a change detector that the host can switch on or off, and a detector that sees a rising or falling change on any line of its group raises a sticky flag. While at least one flag is up, a shared interrupt request line is driven high.

The host reaches the block through a byte-wide port of eight addresses with separate read and write strobes. Six of the addresses return the synchronized level of one group each. The last address is the control register. A write to it loads the per-group enable mask. A read returns the per-group flags together with an active-low interrupt indication, and clears the flags. An interrupt handler therefore reads that address once to learn which groups fired and to acknowledge them. It then reads the input bytes of those groups to find the new levels.

Top module: `cos_input_ctrl`

## Requirements
- R1: After reset the enable mask and all group flags are zero, `irq` is low, and a read of offset 7 returns 0x40.
- R2: Reads of offsets 0, 1, 2, 4, 5 and 6 return the levels of groups 0 to 5, that is of inputs 8g to 8g+7, with the lowest input in bit 0. A level change on `din` appears in this read data two clock edges after it is applied, the delay of the two-flop synchronizer.
- R3: A read of offset 3 returns 0x00. Writes to offsets 0 to 6 have no effect on the input bytes that are read back, on the enable mask, or on the flags.
- R4: A write to offset 7 loads `wdata[5:0]` into the enable mask, where bit n enables the detector of group n. `wdata[7:6]` is ignored.
- R5: Any rising or falling change of an input in an enabled group sets that group's flag, with no single-edge mode. A group whose enable bit is 0 never sets its flag. A flag stays set until offset 7 is read.
- R6: `irq` is high exactly while any flag is set. A read of offset 7 returns the flags in bits 5:0, the inverse of `irq` in bit 6 (0 means an interrupt is pending), and 0 in bit 7.
- R7: A read of offset 7 clears every flag at the clock edge that ends the read. A change that is detected in that same cycle still sets its flag and is not lost.
- R8: After 0 is written to offset 7, no input change sets a flag or raises `irq`. Flags that were already set remain until they are read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 48 | Digital input lines, asynchronous to `clk` |
| addr | input | 3 | Register offset |
| rd | input | 1 | Read strobe, one cycle per read access |
| wr | input | 1 | Write strobe, one cycle per write access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume that `rd` and `wr` are never high together, and that a read of offset 7 lasts one cycle, since each cycle with the strobe high counts as one acknowledge. They also assume that `din` is at zero while reset is released, so the synchronizer does not start with a change already pending. The stimulus drives strobes and inputs only on falling clock edges, raises one strobe per access, and holds `din` at zero through reset. Input changes follow one another by at least three cycles, so the bench knows which clock edge sets each flag.

// File: rtl/cos_pkg.sv
package cos_pkg;

  // Maps a group index onto its read offset. The offset "gap" is skipped.
  function automatic int unsigned grp_to_off(int unsigned grp, int unsigned gap);
    return (grp < gap) ? grp : grp + 1;
  endfunction

  // Builds a status byte: flags in the low bits, inverted irq above them.
  function automatic logic [7:0] status_byte(logic [5:0] flags, logic irq);
    return {1'b0, ~irq, flags};
  endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W      = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_group_det.sv
module cos_group_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic         enable,
  input  logic         clear,
  output logic         edge_any,
  output logic         flag
);
  logic [W-1:0] prev;

  // A change in either direction on any line of the group.
  assign edge_any = |(cur ^ prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      flag <= 1'b0;
    end else begin
      prev <= cur;
      flag <= (flag & ~clear) | (edge_any & enable);
    end
  end
endmodule

// File: rtl/cos_regs.sv
module cos_regs #(
  parameter int unsigned GROUPS  = 6,
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned GAP_OFF = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [GROUPS-1:0]         wbits,
  input  logic [GROUPS*GROUP_W-1:0] levels,
  input  logic [GROUPS-1:0]         flags,
  input  logic                      irq,
  output logic [GROUP_W-1:0]        rdata,
  output logic [GROUPS-1:0]         en_mask,
  output logic                      clr
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'((1 << ADDR_W) - 1);

  logic ctrl_sel;
  logic [GROUP_W-1:0] term [GROUPS];

  assign ctrl_sel = (addr == CTRL_OFF);
  assign clr      = rd & ctrl_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              en_mask <= '0;
    else if (wr && ctrl_sel) en_mask <= wbits;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_rd
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(cos_pkg::grp_to_off(g, GAP_OFF));
    assign term[g] = (addr == OFF) ? levels[g*GROUP_W +: GROUP_W] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < GROUPS; g++) rdata = rdata | term[g];
    if (ctrl_sel) rdata = cos_pkg::status_byte(flags, irq);
  end
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl #(
  parameter int unsigned GROUPS      = 6,
  parameter int unsigned GROUP_W     = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*GROUP_W-1:0] din,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic                      wr,
  input  logic [GROUP_W-1:0]        wdata,
  output logic [GROUP_W-1:0]        rdata,
  output logic                      irq
);
  localparam int unsigned NIN = GROUPS * GROUP_W;

  logic [NIN-1:0]    levels;
  logic [GROUPS-1:0] flags;
  logic [GROUPS-1:0] grp_edge;
  logic [GROUPS-1:0] en_mask;
  logic              rd_clr;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[GROUP_W-1:GROUPS];

  cos_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(levels)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_det
    cos_group_det #(.W(GROUP_W)) u_det (
      .clk(clk), .rst_n(rst_n),
      .cur(levels[g*GROUP_W +: GROUP_W]),
      .enable(en_mask[g]), .clear(rd_clr),
      .edge_any(grp_edge[g]), .flag(flags[g])
    );
  end

  assign irq = |flags;

  cos_regs #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W), .GAP_OFF(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .wbits(wdata[GROUPS-1:0]), .levels(levels), .flags(flags), .irq(irq),
    .rdata(rdata), .en_mask(en_mask), .clr(rd_clr)
  );
endmodule

// File: rtl/cos_input_ctrl_chk.sv
module cos_input_ctrl_chk #(
  parameter int unsigned GROUPS  = 6,
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 rd,
  input logic                 wr,
  input logic [GROUP_W-1:0]   wdata,
  input logic [GROUP_W-1:0]   rdata,
  input logic                 irq,
  input logic [GROUPS-1:0]    flags,
  input logic [GROUPS-1:0]    en_mask,
  input logic [GROUPS-1:0]    grp_edge,
  input logic                 rd_clr
);
  localparam logic [ADDR_W-1:0] CTRL = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] GAP  = ADDR_W'(3);

  // R5: a flag only rises in a group that was enabled.
  p_rise_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(en_mask)) == '0);

  // R5: flags are sticky until a status read.
  p_hold_until_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_clr) |-> ($past(flags) & ~flags) == '0);

  // R7: after a status read only the changes seen in that cycle remain.
  p_read_keeps_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_clr) |-> flags == ($past(grp_edge) & $past(en_mask)));

  // R6: status byte layout.
  p_status_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == CTRL) |-> (rdata[GROUP_W-1] == 1'b0 && rdata[GROUPS] == !irq
                              && rdata[GROUPS-1:0] == flags));

  // R3: the unused offset reads zero.
  p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == GAP) |-> rdata == '0);

  // R4: a control write loads the mask.
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && addr == CTRL) |-> en_mask == $past(wdata[GROUPS-1:0]));

  // R3: no other access alters the mask.
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr && addr == CTRL) |-> $stable(en_mask));
endmodule

bind cos_input_ctrl cos_input_ctrl_chk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .flags(flags), .en_mask(en_mask),
  .grp_edge(grp_edge), .rd_clr(rd_clr)
);

// File: tb/sim_cos_input_ctrl.sv
`timescale 1ns/1ps
module sim_cos_input_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] din = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  cos_input_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [2:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] v);
    addr = a; wdata = v; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_byte(logic [47:0] lv, int off);
    int g;
    if (off == 3 || off == 7) return 8'h00;
    g = (off < 3) ? off : off - 1;
    return lv[g*8 +: 8];
  endfunction

  function automatic logic [7:0] exp_stat(logic [5:0] fl);
    return {1'b0, (fl == 6'd0), fl};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    do_read(3'd7, v); check("R1 status", v, 8'h40);

    // R2 input byte mapping, walking patterns
    for (int p = 0; p < 8; p++) begin
      din = {6{8'h01 << p}} ^ {8'h00, 8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h5A};
      step(2);
      for (int off = 0; off < 8; off++) begin
        if (off != 7) begin
          do_read(3'(off), v); check("R2 input byte", v, exp_byte(din, off));
        end
      end
      do_read(3'd7, v);
    end
    din = '0; step(3); do_read(3'd7, v);

    // R2 latency: visible exactly two edges after the change
    din[9] = 1'b1;
    addr = 3'd1; step(1); #1 check("R2 before sync", rdata, 8'h00);
    step(1); #1 check("R2 after sync", rdata, 8'h02);
    din[9] = 1'b0; step(3);

    // R5/R6/R7 single-line sweep, both edges, all groups enabled
    do_write(3'd7, 8'hFF);
    do_read(3'd7, v);
    for (int b = 0; b < 48; b++) begin
      for (int e = 0; e < 2; e++) begin
        din[b] = ~din[b];
        step(3);
        check("R6 irq high", {7'd0, irq}, 8'h01);
        do_read(3'd7, v); check("R5 flag of group", v, exp_stat(6'(1 << (b / 8))));
        do_read(3'd7, v); check("R7 cleared", v, 8'h40);
        check("R6 irq low", {7'd0, irq}, 8'h00);
      end
    end

    // R4/R5 enable mask sweep
    for (int m = 0; m < 64; m++) begin
      do_write(3'd7, {2'b11, 6'(m)});
      din = ~din;
      step(3);
      do_read(3'd7, v); check("R4 mask gates groups", v, exp_stat(6'(m)));
    end

    // R3 writes to input offsets ignored; offset 3 reads zero
    do_write(3'd7, 8'h2A);
    din = 48'h1234_5678_9ABC;
    step(3);
    do_read(3'd7, v); check("R5 enabled groups flagged", v, exp_stat(6'h2A));
    din[12] = ~din[12];
    step(3);
    for (int off = 0; off < 7; off++) do_write(3'(off), 8'hFF);
    do_read(3'd3, v); check("R3 offset 3", v, 8'h00);
    for (int off = 0; off < 7; off++) begin
      if (off != 3) begin
        do_read(3'(off), v); check("R3 bytes unchanged", v, exp_byte(din, off));
      end
    end
    do_read(3'd7, v); check("R3 flag kept over writes", v, exp_stat(6'h02));
    din[20] = ~din[20];
    step(3);
    do_read(3'd7, v); check("R3 mask kept over writes", v, exp_stat(6'h00));
    din[40] = ~din[40];
    step(3);
    do_read(3'd7, v); check("R3 mask kept group5", v, exp_stat(6'h20));

    // R7 change detected in the read cycle is kept
    do_write(3'd7, 8'h3F);
    din[8] = ~din[8];
    step(3);
    din[16] = ~din[16];
    step(2);
    addr = 3'd7; rd = 1'b1;
    #1 check("R7 read returns old", rdata, exp_stat(6'h02));
    @(negedge clk); rd = 1'b0;
    do_read(3'd7, v); check("R7 same-cycle change kept", v, exp_stat(6'h04));

    // R8 disable all
    din[0] = ~din[0];
    step(3);
    do_write(3'd7, 8'h00);
    din = ~din;
    step(3);
    check("R8 irq from old flag", {7'd0, irq}, 8'h01);
    do_read(3'd7, v); check("R8 old flag kept", v, exp_stat(6'h01));
    din = ~din;
    step(3);
    check("R8 no irq", {7'd0, irq}, 8'h00);
    do_read(3'd7, v); check("R8 no flags", v, 8'h40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule